// File: doc/BRIEF.md
# PHY Link Status Tracker

This block keeps an up-to-date picture of the link on a set of Ethernet PHY ports. It walks the ports one at a time. For each port it asks an external MDIO engine for the PHY-specific status register, then condenses the 16-bit answer into three facts: link up, gigabit or fast speed, and full or half duplex. It stores the condensed word in a per-port cache.

When the condensed word for a port differs from the cached one, the block writes a new speed mode into that port's MAC register. It forces gigabit mode whenever the link has gone down, so that frames still queued for transmit leave quickly.

The cached state is always visible as a per-port summary bus. A single port can also be looked up through an index input, and an index beyond the last port reads back as all zeros.

Top module: `phy_link_tracker`

## Requirements
- R1: Ports are polled in ascending order 0, 1, ..., NUM_PORTS-1 and then wrap back to 0. Every request addresses PHY register 0x11 and names the port as the PHY address. A request is held unchanged until it is accepted.
- R2: At most one MDIO read is outstanding. No new request is raised while a read awaits its response or while a MAC write awaits acceptance.
- R3: The condensed status is zero when bit 10 (link) of the raw status is clear. Otherwise it is the raw status ANDed with 0xE400, so only bits 15, 14, 13 and 10 survive.
- R4: Every cache entry resets to zero. A MAC write is issued only when a port's condensed status differs from its cache entry, and that entry is then replaced. Changes confined to masked-off bits, or a link that stays down, produce no write.
- R5: A MAC mode write goes to address (port << 7) | 0x10.
- R6: The written mode value is 3 when the link is up with bit 15 set, 1 when the link is up with bit 15 clear, and 3 when the link is down.
- R7: link_up[p] is 1 exactly when port p's cached status has bit 10 set.
- R8: The speed code of port p (bits 2p+1:2p of speed_code) is 2 when the link is up with bit 15 set, 1 when the link is up with bit 15 clear, and 2 when the link is down.
- R9: full_duplex[p] is bit 13 of port p's cached status, and is therefore 0 while the link is down.
- R10: The lookup outputs give the summary of the port named by query_port. For an index of NUM_PORTS or above they are all zero.
- R11: After reset every port reads link 0, speed code 2 and duplex 0. No MAC write is pending, and the first request is for port 0.
- R12: A MAC write keeps its valid, address and data stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mdio_req_valid | output | 1 | Read request to the MDIO engine |
| mdio_req_ready | input | 1 | MDIO engine accepts the request |
| mdio_req_phy | output | 5 | PHY address of the request (port index) |
| mdio_req_reg | output | 5 | Register address of the request (0x11) |
| mdio_rsp_valid | input | 1 | Read data valid, one cycle |
| mdio_rsp_data | input | 16 | Raw status word read |
| mac_wr_valid | output | 1 | MAC register write request |
| mac_wr_ready | input | 1 | MAC register space accepts the write |
| mac_wr_addr | output | 11 | MAC register address |
| mac_wr_data | output | 16 | MAC speed mode value |
| link_up | output | 10 | Per-port link flag |
| speed_code | output | 20 | Per-port 2-bit speed code |
| full_duplex | output | 10 | Per-port duplex flag |
| query_port | input | 4 | Port index to look up |
| query_link | output | 1 | Link flag of the looked-up port |
| query_speed | output | 2 | Speed code of the looked-up port |
| query_duplex | output | 1 | Duplex flag of the looked-up port |

## Verification
The bench builds the block with its defaults: ten ports, a 4-bit lookup index, 11-bit MAC addresses and 16-bit MAC data. With these defaults the wrap from port 9 back to port 0 occurs many times. Lookup indices 10 to 15 exercise the out-of-range zero result. The MAC address field of port 9 reaches the top of its 11-bit range.

Raw status words carry noise in the masked bits, bit 14 on its own, and duplex and speed bits on a down link. These show that only real changes of the condensed status cause writes. The MDIO and MAC models stall their ready signals, so the hold rules are exercised.

// File: rtl/plt_pkg.sv
package plt_pkg;

    localparam int          RAW_W        = 16;
    localparam int          PHY_ADDR_W   = 5;
    localparam int          MODE_OFS_W   = 7;
    localparam logic [4:0]  STATUS_REG   = 5'h11;
    localparam logic [15:0] STATUS_MASK  = 16'hE400;
    localparam logic [6:0]  MAC_MODE_OFS = 7'h10;
    localparam logic [1:0]  MODE_GIG     = 2'd3;
    localparam logic [1:0]  MODE_FAST    = 2'd1;
    localparam logic [1:0]  SPD_GIG      = 2'd2;
    localparam logic [1:0]  SPD_FAST     = 2'd1;

    // condensed status: the four bits kept by the mask
    typedef struct packed {
        logic spd_hi;   // raw bit 15
        logic spd_lo;   // raw bit 14
        logic fdx;      // raw bit 13
        logic up;       // raw bit 10
    } lnk_stat_t;

    typedef enum logic [1:0] {
        ST_ISSUE = 2'd0,
        ST_WAIT  = 2'd1,
        ST_WRITE = 2'd2
    } poll_state_e;

    function automatic lnk_stat_t condense(input logic [RAW_W-1:0] raw);
        logic [RAW_W-1:0] kept;
        lnk_stat_t        s;
        kept     = raw & STATUS_MASK;
        s.spd_hi = kept[15];
        s.spd_lo = kept[14];
        s.fdx    = kept[13];
        s.up     = kept[10];
        if (!s.up) s = '0;
        return s;
    endfunction

    function automatic logic [1:0] mac_mode(input lnk_stat_t s);
        return (!s.up || s.spd_hi) ? MODE_GIG : MODE_FAST;
    endfunction

    function automatic logic [1:0] speed_of(input lnk_stat_t s);
        return (!s.up || s.spd_hi) ? SPD_GIG : SPD_FAST;
    endfunction

endpackage

// File: rtl/plt_status_reduce.sv
module plt_status_reduce
    import plt_pkg::*;
(
    input  logic [RAW_W-1:0] raw,
    output lnk_stat_t        reduced
);
    always_comb reduced = condense(raw);
endmodule

// File: rtl/plt_status_cache.sv
module plt_status_cache
    import plt_pkg::*;
#(
    parameter int NUM_PORTS = 10,
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   upd_en,
    input  logic [PORT_W-1:0]      upd_port,
    input  lnk_stat_t              upd_val,
    input  logic [PORT_W-1:0]      rd_port,
    output lnk_stat_t              rd_val,
    input  logic [PORT_W-1:0]      query_port,
    output logic                   query_link,
    output logic [1:0]             query_speed,
    output logic                   query_duplex,
    output logic [NUM_PORTS-1:0]   link_up,
    output logic [2*NUM_PORTS-1:0] speed_code,
    output logic [NUM_PORTS-1:0]   full_duplex
);
    lnk_stat_t entry [NUM_PORTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PORTS; i++) entry[i] <= '0;
        end else if (upd_en) begin
            entry[upd_port] <= upd_val;
        end
    end

    always_comb rd_val = entry[rd_port];

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sum
            assign link_up[p]             = entry[p].up;
            assign speed_code[2*p +: 2]   = speed_of(entry[p]);
            assign full_duplex[p]         = entry[p].fdx;
        end
    endgenerate

    always_comb begin
        query_link   = 1'b0;
        query_speed  = 2'd0;
        query_duplex = 1'b0;
        if (int'(query_port) < NUM_PORTS) begin
            query_link   = entry[query_port].up;
            query_speed  = speed_of(entry[query_port]);
            query_duplex = entry[query_port].fdx;
        end
    end
endmodule

// File: rtl/plt_poll_seq.sv
module plt_poll_seq
    import plt_pkg::*;
#(
    parameter int NUM_PORTS  = 10,
    parameter int PORT_W     = $clog2(NUM_PORTS),
    parameter int ADDR_W     = PORT_W + MODE_OFS_W,
    parameter int MAC_DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [PORT_W-1:0]     cur_port,
    input  logic                  rsp_valid,
    input  lnk_stat_t             rsp_stat,
    input  lnk_stat_t             cached,
    output logic                  upd_en,
    output logic                  wr_valid,
    input  logic                  wr_ready,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [MAC_DATA_W-1:0] wr_data
);
    localparam logic [PORT_W-1:0] LAST_PORT = PORT_W'(NUM_PORTS - 1);

    poll_state_e       state;
    logic [PORT_W-1:0] port_q;
    logic [PORT_W-1:0] port_nxt;
    logic              changed;

    assign port_nxt  = (port_q == LAST_PORT) ? '0 : port_q + 1'b1;
    assign changed   = (rsp_stat != cached);
    assign upd_en    = (state == ST_WAIT) && rsp_valid && changed;
    assign req_valid = (state == ST_ISSUE);
    assign wr_valid  = (state == ST_WRITE);
    assign cur_port  = port_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_ISSUE;
            port_q  <= '0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            unique case (state)
                ST_ISSUE: if (req_ready) state <= ST_WAIT;
                ST_WAIT: begin
                    if (rsp_valid) begin
                        if (changed) begin
                            wr_addr <= {port_q, MAC_MODE_OFS};
                            wr_data <= MAC_DATA_W'(mac_mode(rsp_stat));
                            state   <= ST_WRITE;
                        end else begin
                            port_q <= port_nxt;
                            state  <= ST_ISSUE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (wr_ready) begin
                        port_q <= port_nxt;
                        state  <= ST_ISSUE;
                    end
                end
                default: state <= ST_ISSUE;
            endcase
        end
    end
endmodule

// File: rtl/phy_link_tracker.sv
module phy_link_tracker
    import plt_pkg::*;
#(
    parameter int NUM_PORTS  = 10,
    parameter int PORT_W     = $clog2(NUM_PORTS),
    parameter int ADDR_W     = PORT_W + MODE_OFS_W,
    parameter int MAC_DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic                   mdio_req_valid,
    input  logic                   mdio_req_ready,
    output logic [PHY_ADDR_W-1:0]  mdio_req_phy,
    output logic [4:0]             mdio_req_reg,
    input  logic                   mdio_rsp_valid,
    input  logic [RAW_W-1:0]       mdio_rsp_data,
    output logic                   mac_wr_valid,
    input  logic                   mac_wr_ready,
    output logic [ADDR_W-1:0]      mac_wr_addr,
    output logic [MAC_DATA_W-1:0]  mac_wr_data,
    output logic [NUM_PORTS-1:0]   link_up,
    output logic [2*NUM_PORTS-1:0] speed_code,
    output logic [NUM_PORTS-1:0]   full_duplex,
    input  logic [PORT_W-1:0]      query_port,
    output logic                   query_link,
    output logic [1:0]             query_speed,
    output logic                   query_duplex
);
    lnk_stat_t         rsp_stat;
    lnk_stat_t         cached;
    logic              upd_en;
    logic [PORT_W-1:0] cur_port;

    plt_status_reduce u_reduce (
        .raw     (mdio_rsp_data),
        .reduced (rsp_stat)
    );

    plt_poll_seq #(
        .NUM_PORTS (NUM_PORTS), .PORT_W (PORT_W),
        .ADDR_W (ADDR_W), .MAC_DATA_W (MAC_DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (mdio_req_valid),
        .req_ready (mdio_req_ready),
        .cur_port  (cur_port),
        .rsp_valid (mdio_rsp_valid),
        .rsp_stat  (rsp_stat),
        .cached    (cached),
        .upd_en    (upd_en),
        .wr_valid  (mac_wr_valid),
        .wr_ready  (mac_wr_ready),
        .wr_addr   (mac_wr_addr),
        .wr_data   (mac_wr_data)
    );

    plt_status_cache #(.NUM_PORTS (NUM_PORTS), .PORT_W (PORT_W)) u_cache (
        .clk          (clk),
        .rst          (rst),
        .upd_en       (upd_en),
        .upd_port     (cur_port),
        .upd_val      (rsp_stat),
        .rd_port      (cur_port),
        .rd_val       (cached),
        .query_port   (query_port),
        .query_link   (query_link),
        .query_speed  (query_speed),
        .query_duplex (query_duplex),
        .link_up      (link_up),
        .speed_code   (speed_code),
        .full_duplex  (full_duplex)
    );

    assign mdio_req_phy = PHY_ADDR_W'(cur_port);
    assign mdio_req_reg = STATUS_REG;
endmodule

// File: rtl/phy_link_tracker_checker.sv
module phy_link_tracker_checker
    import plt_pkg::*;
#(
    parameter int NUM_PORTS  = 10,
    parameter int PORT_W     = $clog2(NUM_PORTS),
    parameter int ADDR_W     = PORT_W + MODE_OFS_W,
    parameter int MAC_DATA_W = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   mdio_req_valid,
    input logic                   mdio_req_ready,
    input logic [PHY_ADDR_W-1:0]  mdio_req_phy,
    input logic [4:0]             mdio_req_reg,
    input logic                   mdio_rsp_valid,
    input logic                   mac_wr_valid,
    input logic                   mac_wr_ready,
    input logic [ADDR_W-1:0]      mac_wr_addr,
    input logic [MAC_DATA_W-1:0]  mac_wr_data,
    input logic [NUM_PORTS-1:0]   link_up,
    input logic [2*NUM_PORTS-1:0] speed_code,
    input logic [NUM_PORTS-1:0]   full_duplex,
    input logic [PORT_W-1:0]      query_port,
    input logic                   query_link,
    input logic [1:0]             query_speed,
    input logic                   query_duplex
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst)                                 outstanding <= 1'b0;
        else if (mdio_rsp_valid)                 outstanding <= 1'b0;
        else if (mdio_req_valid && mdio_req_ready) outstanding <= 1'b1;
    end

    assert_req_target_R1: assert property (@(posedge clk) disable iff (rst)
        mdio_req_valid |-> (int'(mdio_req_phy) < NUM_PORTS) && (mdio_req_reg == 5'h11));

    assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
        mdio_req_valid && !mdio_req_ready |=> mdio_req_valid && $stable(mdio_req_phy));

    assert_single_read_R2: assert property (@(posedge clk) disable iff (rst)
        mdio_req_valid |-> !outstanding && !mac_wr_valid);

    assert_write_follows_rsp_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mac_wr_valid) |-> $past(mdio_rsp_valid));

    assert_wr_addr_R5: assert property (@(posedge clk) disable iff (rst)
        mac_wr_valid |-> (mac_wr_addr[6:0] == 7'h10) &&
                         (int'(mac_wr_addr[ADDR_W-1:7]) < NUM_PORTS));

    assert_wr_data_R6: assert property (@(posedge clk) disable iff (rst)
        mac_wr_valid |-> (mac_wr_data == MAC_DATA_W'(1)) || (mac_wr_data == MAC_DATA_W'(3)));

    assert_wr_hold_R12: assert property (@(posedge clk) disable iff (rst)
        mac_wr_valid && !mac_wr_ready |=> mac_wr_valid && $stable(mac_wr_addr) &&
                                          $stable(mac_wr_data));

    assert_query_oor_R10: assert property (@(posedge clk) disable iff (rst)
        (int'(query_port) >= NUM_PORTS) |-> !query_link && (query_speed == 2'd0) && !query_duplex);

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            assert_down_speed_R8: assert property (@(posedge clk) disable iff (rst)
                !link_up[p] |-> speed_code[2*p +: 2] == 2'd2);
            assert_down_duplex_R9: assert property (@(posedge clk) disable iff (rst)
                !link_up[p] |-> !full_duplex[p]);
        end
    endgenerate
endmodule

bind phy_link_tracker phy_link_tracker_checker #(
    .NUM_PORTS (NUM_PORTS), .PORT_W (PORT_W), .ADDR_W (ADDR_W), .MAC_DATA_W (MAC_DATA_W)
) u_chk (
    .clk (clk), .rst (rst),
    .mdio_req_valid (mdio_req_valid), .mdio_req_ready (mdio_req_ready),
    .mdio_req_phy (mdio_req_phy), .mdio_req_reg (mdio_req_reg),
    .mdio_rsp_valid (mdio_rsp_valid),
    .mac_wr_valid (mac_wr_valid), .mac_wr_ready (mac_wr_ready),
    .mac_wr_addr (mac_wr_addr), .mac_wr_data (mac_wr_data),
    .link_up (link_up), .speed_code (speed_code), .full_duplex (full_duplex),
    .query_port (query_port), .query_link (query_link),
    .query_speed (query_speed), .query_duplex (query_duplex)
);

// File: tb/phy_link_tracker_bench.sv
`timescale 1ns/1ps
module phy_link_tracker_bench;
    localparam int NP = 10;
    localparam int PW = 4;
    localparam int AW = 11;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mdio_req_valid, mdio_req_ready = 1'b0;
    logic [4:0]    mdio_req_phy, mdio_req_reg;
    logic          mdio_rsp_valid = 1'b0;
    logic [15:0]   mdio_rsp_data  = '0;
    logic          mac_wr_valid, mac_wr_ready = 1'b0;
    logic [AW-1:0] mac_wr_addr;
    logic [DW-1:0] mac_wr_data;
    logic [NP-1:0] link_up, full_duplex;
    logic [2*NP-1:0] speed_code;
    logic [PW-1:0] query_port = '0;
    logic          query_link, query_duplex;
    logic [1:0]    query_speed;

    always #2 clk = ~clk;   // 250 MHz

    phy_link_tracker u_phy_link_tracker (.*);

    int checks = 0;
    int fails  = 0;

    typedef struct { logic [AW-1:0] addr; logic [DW-1:0] data; } wr_item_t;
    wr_item_t    exp_q[$];
    logic [15:0] phy_stat [NP];
    logic [15:0] shadow   [NP];
    int          rsp_count = 0;
    int          wr_count  = 0;

    function automatic logic [15:0] red_f(input logic [15:0] r);
        return r[10] ? (r & 16'hE400) : 16'h0000;
    endfunction
    function automatic logic [1:0] spd_f(input logic [15:0] red);
        return (!red[10] || red[15]) ? 2'd2 : 2'd1;
    endfunction
    function automatic logic [1:0] mode_f(input logic [15:0] red);
        return (!red[10] || red[15]) ? 2'd3 : 2'd1;
    endfunction

    task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // MDIO engine and MAC register space models; the scoreboard driver pushes
    // the expected MAC write when a response is handed out, the monitor pops it.
    int          rq_wait = 0, wr_wait = 0, lat = 0;
    bit          pending = 1'b0;
    int          pend_port = 0;
    int          exp_port  = 0;

    always @(negedge clk) begin
        if (rst) begin
            mdio_req_ready <= 1'b0; mdio_rsp_valid <= 1'b0; mac_wr_ready <= 1'b0;
            rq_wait = 0; wr_wait = 0; pending = 1'b0; exp_port = 0;
        end else begin
            if (mdio_rsp_valid) begin
                mdio_rsp_valid = 1'b0;
                rsp_count++;
            end
            if (pending) begin
                if (lat == 0) begin
                    logic [15:0] rd;
                    rd = red_f(phy_stat[pend_port]);
                    mdio_rsp_data  = phy_stat[pend_port];
                    mdio_rsp_valid = 1'b1;
                    if (rd != shadow[pend_port]) begin
                        wr_item_t it;
                        shadow[pend_port] = rd;
                        it.addr = AW'((pend_port << 7) | 'h10);
                        it.data = DW'(mode_f(rd));
                        exp_q.push_back(it);
                    end
                    pending = 1'b0;
                end else lat--;
            end
            // R2: no request while a read or a write is open
            if (mdio_req_valid && (pending || mdio_rsp_valid || mac_wr_valid))
                chk("R2 request while busy", 1'b0, 32'(mdio_req_valid), 32'h0);
            mdio_req_ready = 1'b0;
            if (mdio_req_valid && !pending && !mdio_rsp_valid) begin
                if (rq_wait >= 1) begin
                    mdio_req_ready = 1'b1;
                    rq_wait = 0;
                    chk("R1 port order", int'(mdio_req_phy) == exp_port, 32'(mdio_req_phy), 32'(exp_port));
                    chk("R1 status register", mdio_req_reg == 5'h11, 32'(mdio_req_reg), 32'h11);
                    pending   = 1'b1;
                    pend_port = int'(mdio_req_phy);
                    lat       = 2;
                    exp_port  = (exp_port + 1) % NP;
                end else rq_wait++;
            end
            mac_wr_ready = 1'b0;
            if (mac_wr_valid) begin
                if (wr_wait >= 2) begin
                    mac_wr_ready = 1'b1;
                    wr_wait = 0;
                    wr_count++;
                    if (exp_q.size() == 0) begin
                        chk("R4 unexpected MAC write", 1'b0, 32'(mac_wr_addr), 32'h0);
                    end else begin
                        wr_item_t e;
                        e = exp_q.pop_front();
                        chk("R5 write address", mac_wr_addr == e.addr, 32'(mac_wr_addr), 32'(e.addr));
                        chk("R6 write data", mac_wr_data == e.data, 32'(mac_wr_data), 32'(e.data));
                    end
                end else wr_wait++;
            end else wr_wait = 0;
        end
    end

    task automatic wait_polls(input int n);
        int start;
        start = rsp_count;
        while (rsp_count < start + n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_summary(input string tag);
        for (int p = 0; p < NP; p++) begin
            logic [15:0] rd;
            rd = red_f(phy_stat[p]);
            chk({tag, " R7 link"}, link_up[p] == rd[10], 32'(link_up[p]), 32'(rd[10]));
            chk({tag, " R8 speed"}, speed_code[2*p +: 2] == spd_f(rd), 32'(speed_code[2*p +: 2]), 32'(spd_f(rd)));
            chk({tag, " R9 duplex"}, full_duplex[p] == rd[13], 32'(full_duplex[p]), 32'(rd[13]));
        end
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin phy_stat[p] = '0; shadow[p] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        chk("R11 link after reset", link_up == '0, 32'(link_up), 32'h0);
        chk("R11 duplex after reset", full_duplex == '0, 32'(full_duplex), 32'h0);
        chk("R11 speed after reset", speed_code == {NP{2'd2}}, 32'(speed_code), 32'(2*NP'(0)) | 32'h000AAAAA);
        chk("R11 no write after reset", mac_wr_valid == 1'b0, 32'(mac_wr_valid), 32'h0);
        chk("R11 first request port 0", mdio_req_valid && mdio_req_phy == 5'd0, 32'(mdio_req_phy), 32'h0);

        // all links down: no writes (R4)
        wait_polls(2 * NP);
        chk("R4 no write while all down", wr_count == 0, 32'(wr_count), 32'h0);

        // mixed statuses with noise bits (R3)
        @(negedge clk);
        phy_stat[0] = 16'hA7FF;   // gig full, noise
        phy_stat[1] = 16'h0400;   // fast half
        phy_stat[2] = 16'h6400;   // bit 14 alone: fast, full
        phy_stat[3] = 16'hA000;   // down with speed/duplex bits
        phy_stat[4] = 16'hE4FF;   // reserved speed pattern, bit 15 set
        phy_stat[9] = 16'h2400;   // fast full on the last port
        wait_polls(2 * NP);
        chk("R4 writes for changed ports", wr_count == 5, 32'(wr_count), 32'd5);
        check_summary("B");
        chk("R3 bit14 alone is fast", speed_code[5:4] == 2'd1, 32'(speed_code[5:4]), 32'd1);
        chk("R3 down port masked", {link_up[3], full_duplex[3]} == 2'b00, 32'({link_up[3], full_duplex[3]}), 32'h0);

        // lookup port (R10)
        for (int q = 0; q < 16; q++) begin
            @(negedge clk);
            query_port = PW'(q);
            #1;
            if (q >= NP) begin
                chk("R10 out-of-range lookup", {query_link, query_speed, query_duplex} == 4'b0,
                    32'({query_link, query_speed, query_duplex}), 32'h0);
            end else begin
                logic [15:0] rd;
                rd = red_f(phy_stat[q]);
                chk("R10 lookup", {query_link, query_speed, query_duplex} == {rd[10], spd_f(rd), rd[13]},
                    32'({query_link, query_speed, query_duplex}), 32'({rd[10], spd_f(rd), rd[13]}));
            end
        end

        // port 0 drops, port 1 changes only masked bits
        @(negedge clk);
        phy_stat[0] = 16'h8000;
        phy_stat[1] = 16'h0401;
        wait_polls(2 * NP);
        chk("R4 only the drop writes", wr_count == 6, 32'(wr_count), 32'd6);
        chk("R6 drop forces gig speed code", speed_code[1:0] == 2'd2, 32'(speed_code[1:0]), 32'd2);

        // port 1 goes gigabit
        @(negedge clk);
        phy_stat[1] = 16'h8400;
        wait_polls(2 * NP);
        chk("R4 upgrade writes once", wr_count == 7, 32'(wr_count), 32'd7);
        check_summary("C");

        repeat (20) @(negedge clk);
        chk("R4 scoreboard drained", exp_q.size() == 0, 32'(exp_q.size()), 32'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule